// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Bootstrap Refresh

This block sits between a pulse-width controller and the gate drivers of a totem-pole power stage. It takes an enable, a direction command and a shutdown request from the protection logic, and produces two drive enables, one for the upper switch and one for the lower switch. Before a command reaches the sequencer it passes a glitch filter. The sequencer puts a guaranteed all-off gap before every turn-on, and it keeps each on pulse at least a minimum length, so the two switches never conduct together.

When the upper switch is held on without a break, its floating supply drains. The block handles this with a periodic refresh. It turns the upper switch off, waits out the gap, pulses the lower switch for one minimum on time, waits out a second gap, and then returns the upper switch. A flag output marks the refresh. Any break in the upper pulse restarts the refresh interval. The shutdown input overrides all of this, including a refresh in progress. Every time is a parameter in clock cycles.

Top module: `hb_gate_sequencer`

## Requirements
- R1: When the filtered enable is low, both drive outputs go low once the active pulse has met its minimum on time, and they stay low.
- R2: With the filtered enable high, a filtered direction of 1 selects the upper drive and 0 selects the lower drive. Starting from a settled all-off state, the selected drive rises FILT_CYC+1 cycles after the raw inputs change.
- R3: A change on enable or direction that lasts fewer than FILT_CYC consecutive cycles has no effect on any output.
- R4: drive_hi_o and drive_lo_o are never both 1 in the same cycle.
- R5: Every rising edge of either drive follows at least GAP = max(DEAD_CYC, MIN_OFF_CYC) cycles with both drives low. This holds after reset, after a refresh and after a shutdown.
- R6: Each drive pulse lasts at least MIN_ON_CYC cycles unless the shutdown input cuts it short.
- R7: After REFRESH_CYC consecutive cycles of the upper drive, the block runs the refresh in this order: upper off, a GAP-cycle all-off interval, a lower pulse of exactly MIN_ON_CYC cycles, a second GAP-cycle all-off interval, then upper on again if still commanded.
- R8: refresh_o is 1 from the first cycle after the upper drive drops for a refresh through the last cycle of the refresh lower pulse. The upper drive is never on while refresh_o is 1.
- R9: The refresh interval counts only the current unbroken upper pulse. Upper pulses shorter than REFRESH_CYC never cause a refresh.
- R10: A 1 on fault_stop_i sampled at a clock edge forces both drives and refresh_o to 0 from the next cycle on. They stay 0 while fault_stop_i is held. After fault_stop_i is released, a drive turns on no earlier than GAP cycles later.
- R11: During and right after synchronous active-low reset, all three outputs are 0.
- R12: If the filtered command leaves "upper" in the same cycle that the refresh interval expires, the command wins: no refresh is started and refresh_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| enable_i | input | 1 | Raw enable command; low turns both switches off |
| dir_up_i | input | 1 | Raw direction command; 1 = upper, 0 = lower |
| fault_stop_i | input | 1 | Shutdown request from the protection logic |
| drive_hi_o | output | 1 | Upper switch drive enable |
| drive_lo_o | output | 1 | Lower switch drive enable |
| refresh_o | output | 1 | High while a bootstrap refresh sequence runs |

## Verification
Two events can land on the same clock edge. One is the expiry of the refresh interval. The other is the arrival of a filtered command change, or a shutdown during the refresh sequence. A directed case times the raw direction change so that the filter delivers it one edge before expiry, and then checks that refresh_o never rises while the lower drive still turns on. A second case raises the shutdown while refresh_o is high and checks that all outputs fall in the next cycle. Random command and shutdown stimulus is also compared every cycle against a cycle model in the bench.

// File: rtl/hbg_pkg.sv
`timescale 1ns/1ps
// Shared types for the half-bridge gate sequencer.
// Assumes: nothing beyond the SystemVerilog 2017 language.
package hbg_pkg;

    // Conduction phase of the sequencer.
    typedef enum logic [1:0] {
        PH_GAP = 2'd0,   // both drives off
        PH_HI  = 2'd1,   // upper drive on
        PH_LO  = 2'd2,   // lower drive on (commanded)
        PH_RLO = 2'd3    // lower drive on (refresh pulse)
    } phase_e;

    // Filtered command decoded from enable and direction.
    typedef enum logic [1:0] {
        W_OFF = 2'd0,
        W_UP  = 2'd1,
        W_DN  = 2'd2
    } want_e;

    // Larger of two cycle counts.
    function automatic int max_cyc(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hbg_glitch_filter.sv
`timescale 1ns/1ps
// Glitch filter for one command input. The clean output takes a new value
// only after the raw input has held that value for HOLD_CYC sampled edges
// in a row. Assumes: raw_i is already synchronous to clk_i, HOLD_CYC >= 1.
module hbg_glitch_filter #(
    parameter int HOLD_CYC = 22
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] run_q;

    // Count agreeing samples of a differing raw value; adopt it at HOLD_CYC.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_q   <= '0;
            clean_o <= 1'b0;
        end else if (raw_i == clean_o) begin
            run_q <= '0;
        end else if (run_q == CW'(HOLD_CYC - 1)) begin
            run_q   <= '0;
            clean_o <= raw_i;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/hbg_refresh_timer.sv
`timescale 1ns/1ps
// Refresh interval timer. It counts the cycles of the current unbroken upper
// pulse and raises due_o once PERIOD_CYC cycles have passed. Any cycle with
// the upper drive off clears it. Assumes: PERIOD_CYC > the minimum on time.
module hbg_refresh_timer #(
    parameter int PERIOD_CYC = 17500
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hi_on_i,
    output logic due_o
);
    localparam int PW = $clog2(PERIOD_CYC + 1);
    localparam logic [PW-1:0] LAST = PW'(PERIOD_CYC - 1);

    logic [PW-1:0] age_q;

    // Age of the current upper pulse, saturating at its last count.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !hi_on_i) begin
            age_q <= '0;
        end else if (age_q != LAST) begin
            age_q <= age_q + 1'b1;
        end
    end

    // Due while the upper pulse has reached the full interval.
    always_comb due_o = hi_on_i && (age_q == LAST);
endmodule

// File: rtl/hbg_phase_ctrl.sv
`timescale 1ns/1ps
// Conduction phase controller. It moves between the all-off gap, upper-on,
// lower-on and refresh-lower phases. It holds every pulse for the minimum on
// time and every gap for GAP_CYC. A shutdown forces the gap at once.
// Assumes: want_i is already filtered; refresh_due_i is raised only in PH_HI.
module hbg_phase_ctrl
    import hbg_pkg::*;
#(
    parameter int GAP_CYC    = 125,
    parameter int MIN_ON_CYC = 115
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  want_e want_i,
    input  logic  fault_i,
    input  logic  refresh_due_i,
    output logic  drive_hi_o,
    output logic  drive_lo_o,
    output logic  refresh_o
);
    localparam int TW = $clog2(max_cyc(GAP_CYC, MIN_ON_CYC) + 1);
    localparam logic [TW-1:0] GAP_LAST = TW'(GAP_CYC - 1);
    localparam logic [TW-1:0] ON_LAST  = TW'(MIN_ON_CYC - 1);

    phase_e        ph_q;
    logic [TW-1:0] tmr_q;
    logic          pend_q;

    // Phase, time-in-phase and refresh-pending update; shutdown comes first.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || fault_i) begin
            ph_q   <= PH_GAP;
            tmr_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (tmr_q != '1) tmr_q <= tmr_q + 1'b1;
            unique case (ph_q)
                PH_GAP: if (tmr_q >= GAP_LAST) begin
                    if (pend_q && want_i == W_UP) begin
                        ph_q  <= PH_RLO;
                        tmr_q <= '0;
                    end else begin
                        pend_q <= 1'b0;
                        if (want_i == W_UP) begin
                            ph_q  <= PH_HI;
                            tmr_q <= '0;
                        end else if (want_i == W_DN) begin
                            ph_q  <= PH_LO;
                            tmr_q <= '0;
                        end
                    end
                end
                PH_HI: if (tmr_q >= ON_LAST) begin
                    if (want_i != W_UP) begin
                        ph_q  <= PH_GAP;
                        tmr_q <= '0;
                    end else if (refresh_due_i) begin
                        ph_q   <= PH_GAP;
                        tmr_q  <= '0;
                        pend_q <= 1'b1;
                    end
                end
                PH_LO: if (tmr_q >= ON_LAST && want_i != W_DN) begin
                    ph_q  <= PH_GAP;
                    tmr_q <= '0;
                end
                PH_RLO: if (tmr_q >= ON_LAST) begin
                    ph_q   <= PH_GAP;
                    tmr_q  <= '0;
                    pend_q <= 1'b0;
                end
                default: ph_q <= PH_GAP;
            endcase
        end
    end

    // Decode the drive enables from the registered phase.
    always_comb begin
        drive_hi_o = (ph_q == PH_HI);
        drive_lo_o = (ph_q == PH_LO) || (ph_q == PH_RLO);
        refresh_o  = pend_q;
    end
endmodule

// File: rtl/hb_gate_sequencer.sv
`timescale 1ns/1ps
// Half-bridge gate sequencer top. It filters the enable and direction
// commands, decodes them into a wanted conduction state, and drives the
// phase controller and the bootstrap refresh timer.
// Assumes: inputs are synchronous to clk_i; REFRESH_CYC > MIN_ON_CYC.
module hb_gate_sequencer
    import hbg_pkg::*;
#(
    parameter int FILT_CYC    = 22,
    parameter int DEAD_CYC    = 125,
    parameter int MIN_ON_CYC  = 115,
    parameter int MIN_OFF_CYC = 100,
    parameter int REFRESH_CYC = 17500
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    input  logic dir_up_i,
    input  logic fault_stop_i,
    output logic drive_hi_o,
    output logic drive_lo_o,
    output logic refresh_o
);
    localparam int GAP_CYC = max_cyc(DEAD_CYC, MIN_OFF_CYC);
    localparam int N_CMD   = 2;

    logic [N_CMD-1:0] raw_cmd;
    logic [N_CMD-1:0] clean_cmd;
    want_e            want;
    logic             refresh_due;

    assign raw_cmd = {dir_up_i, enable_i};

    // One glitch filter per command input.
    for (genvar g = 0; g < N_CMD; g++) begin : g_filt
        hbg_glitch_filter #(.HOLD_CYC(FILT_CYC)) u_filt (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .raw_i   (raw_cmd[g]),
            .clean_o (clean_cmd[g])
        );
    end

    // Decode the filtered enable and direction into the wanted state.
    always_comb begin
        if (!clean_cmd[0])     want = W_OFF;
        else if (clean_cmd[1]) want = W_UP;
        else                   want = W_DN;
    end

    hbg_refresh_timer #(.PERIOD_CYC(REFRESH_CYC)) u_refresh (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hi_on_i (drive_hi_o),
        .due_o   (refresh_due)
    );

    hbg_phase_ctrl #(.GAP_CYC(GAP_CYC), .MIN_ON_CYC(MIN_ON_CYC)) u_phase (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .want_i        (want),
        .fault_i       (fault_stop_i),
        .refresh_due_i (refresh_due),
        .drive_hi_o    (drive_hi_o),
        .drive_lo_o    (drive_lo_o),
        .refresh_o     (refresh_o)
    );
endmodule

// File: rtl/hb_gate_sequencer_chk.sv
`timescale 1ns/1ps
// Property checker for the gate sequencer, bound to the top module.
// It watches the ports only and uses its own run-length counters.
// Assumes: GAP_CYC and MIN_ON_CYC match the bound instance.
module hb_gate_sequencer_chk #(
    parameter int GAP_CYC    = 125,
    parameter int MIN_ON_CYC = 115
) (
    input logic clk_i,
    input logic rst_ni,
    input logic fault_stop_i,
    input logic drive_hi_o,
    input logic drive_lo_o,
    input logic refresh_o
);
    localparam int CW = $clog2((GAP_CYC > MIN_ON_CYC ? GAP_CYC : MIN_ON_CYC) + 1);

    logic [CW-1:0] off_run, hi_run, lo_run;

    // Saturating run lengths of all-off, upper-on and lower-on.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            off_run <= '0;
            hi_run  <= '0;
            lo_run  <= '0;
        end else begin
            off_run <= (drive_hi_o || drive_lo_o) ? '0 :
                       (off_run < CW'(GAP_CYC) ? off_run + 1'b1 : off_run);
            hi_run  <= !drive_hi_o ? '0 :
                       (hi_run < CW'(MIN_ON_CYC) ? hi_run + 1'b1 : hi_run);
            lo_run  <= !drive_lo_o ? '0 :
                       (lo_run < CW'(MIN_ON_CYC) ? lo_run + 1'b1 : lo_run);
        end
    end

    a_r4_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(drive_hi_o && drive_lo_o));

    a_r10_fault_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_stop_i |=> (!drive_hi_o && !drive_lo_o && !refresh_o));

    a_r5_gap_before_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(drive_hi_o) || $rose(drive_lo_o)) |-> (off_run >= CW'(GAP_CYC)));

    a_r6_hi_min_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(drive_hi_o) && !$past(fault_stop_i)) |-> (hi_run >= CW'(MIN_ON_CYC)));

    a_r6_lo_min_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(drive_lo_o) && !$past(fault_stop_i)) |-> (lo_run >= CW'(MIN_ON_CYC)));

    a_r8_refresh_no_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
        refresh_o |-> !drive_hi_o);
endmodule

bind hb_gate_sequencer hb_gate_sequencer_chk #(
    .GAP_CYC    (GAP_CYC),
    .MIN_ON_CYC (MIN_ON_CYC)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fault_stop_i (fault_stop_i),
    .drive_hi_o   (drive_hi_o),
    .drive_lo_o   (drive_lo_o),
    .refresh_o    (refresh_o)
);

// File: tb/hb_gate_sequencer_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random stimulus. A cycle
// model built from the requirements is compared at every falling edge.
module hb_gate_sequencer_tb_top;
    localparam int FILT   = 3;
    localparam int DEAD   = 4;
    localparam int MINON  = 6;
    localparam int MINOFF = 5;
    localparam int REFR   = 40;
    localparam int GAP    = (DEAD > MINOFF) ? DEAD : MINOFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, dir = 1'b0, fault = 1'b0;
    logic hi, lo, rf;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 0;
    string tag = "R11";

    always #10 clk = ~clk;

    hb_gate_sequencer #(
        .FILT_CYC(FILT), .DEAD_CYC(DEAD), .MIN_ON_CYC(MINON),
        .MIN_OFF_CYC(MINOFF), .REFRESH_CYC(REFR)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .dir_up_i(dir),
        .fault_stop_i(fault), .drive_hi_o(hi), .drive_lo_o(lo), .refresh_o(rf)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Cycle model: mode 0 gap, 1 upper, 2 lower, 3 refresh lower.
    int m_ef, m_df, m_ec, m_dc, m_mode, m_age, m_hage, m_pend;
    always @(posedge clk) begin
        int w, nm, nage, npend;
        bit due;
        if (!rst_n || fault) begin
            if (!rst_n) begin
                m_ef = 0; m_df = 0; m_ec = 0; m_dc = 0; m_hage = 0;
            end
            nm = 0; nage = 0; npend = 0;
        end else begin
            w = (m_ef == 0) ? 0 : ((m_df != 0) ? 1 : 2);
            due = (m_mode == 1) && (m_hage >= REFR - 1);
            nm = m_mode; npend = m_pend; nage = (m_age < 1000) ? m_age + 1 : m_age;
            case (m_mode)
                0: if (m_age >= GAP - 1) begin
                    if (m_pend != 0 && w == 1) begin nm = 3; nage = 0; end
                    else begin
                        npend = 0;
                        if (w != 0) begin nm = w; nage = 0; end
                    end
                end
                1: if (m_age >= MINON - 1) begin
                    if (w != 1) begin nm = 0; nage = 0; end
                    else if (due) begin nm = 0; nage = 0; npend = 1; end
                end
                2: if (m_age >= MINON - 1 && w != 2) begin nm = 0; nage = 0; end
                default: if (m_age >= MINON - 1) begin nm = 0; nage = 0; npend = 0; end
            endcase
        end
        if (rst_n) begin
            m_hage = (m_mode == 1) ? ((m_hage < REFR - 1) ? m_hage + 1 : m_hage) : 0;
            if (int'(en) == m_ef) m_ec = 0;
            else begin m_ec++; if (m_ec == FILT) begin m_ef = int'(en); m_ec = 0; end end
            if (int'(dir) == m_df) m_dc = 0;
            else begin m_dc++; if (m_dc == FILT) begin m_df = int'(dir); m_dc = 0; end end
        end
        m_mode = nm; m_age = nage; m_pend = npend;
    end

    // Per-cycle comparison against the model, plus the overlap rule (R4).
    always @(negedge clk) if (cmp_on) begin
        check(tag, "drive_hi_o vs model", int'(hi), int'(m_mode == 1));
        check(tag, "drive_lo_o vs model", int'(lo), int'(m_mode >= 2));
        check(tag, "refresh_o vs model", int'(rf), m_pend);
        check("R4", "overlap", int'(hi && lo), 0);
    end

    function automatic bit sig(input int sel);
        case (sel)
            0: return hi;
            1: return lo;
            2: return rf;
            default: return !hi && !lo;
        endcase
    endfunction

    task automatic run_len(input int sel, output int n);
        n = 0;
        while (sig(sel) && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic wait_until(input int sel, input int lim, output int lat);
        lat = 0;
        while (!sig(sel) && lat < lim) begin @(negedge clk); lat++; end
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int n, lat, seen_rf, seen_lo, cnt;
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk);
        check("R11", "hi in reset", int'(hi), 0);
        check("R11", "lo in reset", int'(lo), 0);
        check("R11", "refresh in reset", int'(rf), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "hi after reset", int'(hi), 0);
        check("R11", "refresh after reset", int'(rf), 0);
        cmp_on = 1;
        tag = "R1";
        repeat (10) @(negedge clk);
        check("R1", "both off with enable low", int'(hi || lo), 0);

        // R2: latency from idle to upper on.
        tag = "R2";
        en = 1'b1; dir = 1'b1;
        wait_until(0, 50, lat);
        check("R2", "upper turn-on latency", lat, FILT + 1);
        check("R2", "lower stays off", int'(lo), 0);

        // R7 / R8 / R5: full refresh sequence.
        tag = "R7";
        run_len(0, n);
        check("R7", "upper run before refresh", n, REFR);
        check("R8", "refresh flag at upper drop", int'(rf), 1);
        run_len(3, n);
        check("R5", "gap before refresh pulse", n, GAP);
        check("R8", "refresh flag during lower pulse", int'(rf), 1);
        run_len(1, n);
        check("R7", "refresh lower pulse width", n, MINON);
        check("R8", "refresh flag cleared", int'(rf), 0);
        run_len(3, n);
        check("R5", "gap after refresh pulse", n, GAP);
        check("R7", "upper restored", int'(hi), 1);

        // R12: command change lands on the refresh expiry edge.
        tag = "R12";
        repeat (REFR - 1 - FILT) @(negedge clk);
        dir = 1'b0;
        seen_rf = 0; seen_lo = 0;
        repeat (25) begin
            @(negedge clk);
            if (rf) seen_rf = 1;
            if (lo) seen_lo = 1;
        end
        check("R12", "refresh suppressed by command", seen_rf, 0);
        check("R2", "lower selected after change", seen_lo, 1);

        // R9: toggling faster than the interval never refreshes.
        tag = "R9";
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            dir = i[0];
            repeat (15) begin @(negedge clk); if (rf) cnt++; end
        end
        check("R9", "refresh cycles while toggling", cnt, 0);

        // R3: short glitches on direction and enable are ignored.
        tag = "R3";
        en = 1'b0;
        repeat (20) @(negedge clk);
        en = 1'b1; dir = 1'b1;
        wait_until(0, 50, lat);
        repeat (5) @(negedge clk);
        dir = 1'b0;
        repeat (FILT - 1) @(negedge clk);
        dir = 1'b1;
        cnt = 0;
        repeat (10) begin @(negedge clk); if (hi) cnt++; end
        check("R3", "upper held through direction glitch", cnt, 10);
        en = 1'b0;
        repeat (FILT - 1) @(negedge clk);
        en = 1'b1;
        cnt = 0;
        repeat (8) begin @(negedge clk); if (hi) cnt++; end
        check("R3", "upper held through enable glitch", cnt, 8);

        // R1 / R6: enable drop and minimum on time.
        tag = "R1";
        en = 1'b0;
        repeat (FILT + MINON + 2) @(negedge clk);
        check("R1", "both off after enable drop", int'(hi || lo), 0);
        tag = "R6";
        dir = 1'b0; en = 1'b1;
        wait_until(1, 50, lat);
        en = 1'b0;
        run_len(1, n);
        check("R6", "lower held for minimum on", n, MINON);

        // R10: shutdown during upper conduction and during a refresh.
        tag = "R10";
        en = 1'b1; dir = 1'b1;
        wait_until(0, 50, lat);
        fault = 1'b1;
        @(negedge clk);
        check("R10", "drives off one cycle after fault", int'(hi || lo), 0);
        repeat (3) @(negedge clk);
        check("R10", "drives off while fault held", int'(hi || lo), 0);
        fault = 1'b0;
        wait_until(0, 50, lat);
        check("R10", "restart delay after fault", lat, GAP);
        wait_until(2, 80, lat);
        check("R8", "refresh started", int'(rf), 1);
        fault = 1'b1;
        @(negedge clk);
        check("R10", "refresh aborted by fault", int'(rf || hi || lo), 0);
        fault = 1'b0;

        // Random stimulus checked by the model.
        tag = "R2";
        for (int s = 0; s < 120; s++) begin
            int dur;
            en    = ($urandom % 4) != 0;
            dir   = $urandom % 2;
            fault = ($urandom % 16) == 0;
            dur   = 1 + ($urandom % 50);
            repeat (dur) @(negedge clk);
        end
        fault = 1'b0;
        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule